// File: doc/BRIEF.md
# Timebase Interrupt and Watchdog Controller

The block divides its clock with a free-running binary counter and raises a periodic timeout. Four counter taps are on offer, and a two-bit rate field in one 8-bit control/status register picks which tap sets the period. Each timeout sets a sticky interrupt flag. An interrupt request is presented while that flag and an enable bit are both 1, and software acknowledges it by writing 1 to a separate clear-strobe bit. The divider has no reset, so it keeps its phase through a reset, and the first timeout after reset comes at a time that depends on where the count happened to be.

The same timeout stream drives a small watchdog. When software turns the watchdog on, it counts timeouts and pulses a one-cycle reset output after a set number of them. Software restarts that count by writing 1 to a watchdog clear strobe. The watchdog enable may be written only once after each reset. Because one rate field controls both the interrupt period and the watchdog period, they always change together.

The CPU side is a plain single-register port: a write strobe with a data byte, and a read-data bus that always shows the register contents.

Top module: `tbase_wdog`

## Requirements
- R1: While reset is held, and just after it, the register reads 0x30, and irq and wd_rst are 0.
- R2: The read layout is: bit 7 = flag, bit 6 = irq enable, bits 5:4 = rate, bit 1 = watchdog enable. Bits 3, 2 and 0 always read 0. A write loads bit 6 and bits 5:4 from the data byte.
- R3: A timeout occurs on each clock edge where the low TAP_BASE+TAP_STEP*rate bits of the free-running divider are all ones. That edge sets the flag, which shows in the next read.
- R4: Only a write with bit 3 = 1 clears the flag. Writing bit 7 has no effect.
- R5: When a timeout and a flag-clear write fall on the same edge, the flag ends up 1.
- R6: irq is 1 exactly when the flag and the irq enable are both 1.
- R7: Only the first write after reset updates the watchdog enable (bit 1). Every later write leaves it unchanged.
- R8: Reset does not clear the divider. The first timeout after reset follows the divider's phase, which keeps running through reset.
- R9: The watchdog counts timeouts only while it is enabled. On the WD_PERIODS-th counted timeout it pulses wd_rst for one cycle and starts over.
- R10: A write with bit 0 = 1 zeroes the watchdog count. This takes priority over a timeout on the same edge.
- R11: Changing the rate changes the timeout spacing to 2^(TAP_BASE+TAP_STEP*rate) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also feeds the divider |
| rst | input | 1 | Synchronous active-high reset, does not touch the divider |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq | output | 1 | Timebase interrupt request |
| wd_rst | output | 1 | One-cycle watchdog timeout pulse |

## Verification
The bench builds the block with TAP_BASE=2, TAP_STEP=1 and WD_PERIODS=4. This gives timeout periods of 4, 8, 16 and 32 clocks and a watchdog that fires every 16 clocks at the fastest rate. With these values, timeout collisions with writes, the rate-dependent spacing, the divider's phase surviving a mid-run reset, and both a starved and a regularly cleared watchdog all occur within a few hundred cycles. A behavioural model tracks the divider from time zero and is compared with the outputs on every cycle.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int REG_W     = 8;
  localparam int FLAG_BIT  = 7;
  localparam int IE_BIT    = 6;
  localparam int RATE_HI   = 5;
  localparam int RATE_LO   = 4;
  localparam int TBCLR_BIT = 3;
  localparam int WDEN_BIT  = 1;
  localparam int WDCLR_BIT = 0;
  localparam int NUM_RATES = 4;

  typedef logic [1:0] rate_t;

  localparam rate_t RATE_RESET = 2'b11;
endpackage

// File: rtl/tbw_divider.sv
module tbw_divider #(
  parameter int TAP_BASE = 4,
  parameter int TAP_STEP = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  tbw_pkg::rate_t rate,
  output logic          tick
);
  import tbw_pkg::*;

  localparam int DIV_W = TAP_BASE + TAP_STEP * (NUM_RATES - 1);

  // Free running: deliberately outside reset, keeps phase across resets.
  logic [DIV_W-1:0] cnt = '0;
  logic [NUM_RATES-1:0] tap_hit;

  always_ff @(posedge clk) begin
    cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
    localparam int TW = TAP_BASE + TAP_STEP * g;
    assign tap_hit[g] = &cnt[TW-1:0];
  end

  assign tick = tap_hit[rate];

  // Timeouts are never back to back, even across a rate change.
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/tbw_ctrl.sv
module tbw_ctrl (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [tbw_pkg::REG_W-1:0]  wr_data,
  input  logic                       tick,
  output logic                       flag,
  output logic                       ie,
  output tbw_pkg::rate_t             rate,
  output logic                       wd_en,
  output logic                       wd_clr,
  output logic [tbw_pkg::REG_W-1:0]  rd_data
);
  import tbw_pkg::*;

  logic locked;
  logic flag_clr;

  assign flag_clr = wr_en && wr_data[TBCLR_BIT];
  assign wd_clr   = wr_en && wr_data[WDCLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      ie     <= 1'b0;
      rate   <= RATE_RESET;
      wd_en  <= 1'b0;
      locked <= 1'b0;
    end else begin
      // A timeout outranks a clear on the same edge.
      if (tick)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (wr_en) begin
        ie   <= wr_data[IE_BIT];
        rate <= wr_data[RATE_HI:RATE_LO];
        if (!locked) begin
          wd_en  <= wr_data[WDEN_BIT];
          locked <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rd_data                  = '0;
    rd_data[FLAG_BIT]        = flag;
    rd_data[IE_BIT]          = ie;
    rd_data[RATE_HI:RATE_LO] = rate;
    rd_data[WDEN_BIT]        = wd_en;
  end

  assert_flag_fall_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(wr_en && wr_data[TBCLR_BIT]));
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> flag);
  assert_wden_locked_R7: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(wd_en));
endmodule

// File: rtl/tbw_wdog.sv
module tbw_wdog #(
  parameter int WD_PERIODS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  logic tick,
  output logic wd_rst
);
  localparam int CW = (WD_PERIODS > 2) ? $clog2(WD_PERIODS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WD_PERIODS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wd_rst <= 1'b0;
    end else begin
      wd_rst <= 1'b0;
      if (!en || clr) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LAST) begin
          cnt    <= '0;
          wd_rst <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_fire_needs_en_R9: assert property (@(posedge clk) disable iff (rst)
    wd_rst |-> $past(en));
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    wd_rst |=> !wd_rst);
  assert_clear_blocks_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !wd_rst);
endmodule

// File: rtl/tbase_wdog.sv
module tbase_wdog #(
  parameter int TAP_BASE   = 4,
  parameter int TAP_STEP   = 2,
  parameter int WD_PERIODS = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       wd_rst
);
  import tbw_pkg::*;

  logic  tick;
  logic  flag;
  logic  ie;
  rate_t rate;
  logic  wd_en;
  logic  wd_clr;

  tbw_divider #(.TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)) u_div (
    .clk  (clk),
    .rst  (rst),
    .rate (rate),
    .tick (tick)
  );

  tbw_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .tick    (tick),
    .flag    (flag),
    .ie      (ie),
    .rate    (rate),
    .wd_en   (wd_en),
    .wd_clr  (wd_clr),
    .rd_data (rd_data)
  );

  tbw_wdog #(.WD_PERIODS(WD_PERIODS)) u_wdog (
    .clk    (clk),
    .rst    (rst),
    .en     (wd_en),
    .clr    (wd_clr),
    .tick   (tick),
    .wd_rst (wd_rst)
  );

  assign irq = flag && ie;

  assert_irq_matches_reg_R6: assert property (@(posedge clk) disable iff (rst)
    irq == (rd_data[FLAG_BIT] && rd_data[IE_BIT]));
  assert_reset_value_R1: assert property (@(posedge clk)
    $past(rst) |-> (rd_data == 8'h30 && !wd_rst));
endmodule

// File: tb/tbase_wdog_tb.sv
module tbase_wdog_tb;
  localparam int TB_BASE = 2;
  localparam int TB_STEP = 1;
  localparam int TB_WD   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq;
  logic       wd_rst;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tbase_wdog #(.TAP_BASE(TB_BASE), .TAP_STEP(TB_STEP), .WD_PERIODS(TB_WD)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .wd_rst(wd_rst)
  );

  // Behavioural reference model; divider phase counted from time zero.
  int  m_div = 0;
  bit  m_flag, m_ie, m_wden, m_lock, m_wdrst, m_valid;
  int  m_rate = 3;
  int  m_wcnt = 0;

  function automatic int period(input int r);
    return 1 << (TB_BASE + TB_STEP * r);
  endfunction

  function automatic bit tick_next();
    return (m_div % period(m_rate)) == period(m_rate) - 1;
  endfunction

  always @(posedge clk) begin
    bit t;
    cyc++;
    t = tick_next();
    if (rst) begin
      m_flag = 0; m_ie = 0; m_rate = 3; m_wden = 0; m_lock = 0;
      m_wcnt = 0; m_wdrst = 0;
    end else begin
      bit old_en;
      old_en = m_wden;
      if (t) m_flag = 1;
      else if (wr_en && wr_data[3]) m_flag = 0;
      if (wr_en) begin
        m_ie = wr_data[6];
        m_rate = int'(wr_data[5:4]);
        if (!m_lock) begin m_wden = wr_data[1]; m_lock = 1; end
      end
      m_wdrst = 0;
      if (!old_en || (wr_en && wr_data[0])) m_wcnt = 0;
      else if (t) begin
        if (m_wcnt == TB_WD - 1) begin m_wcnt = 0; m_wdrst = 1; end
        else m_wcnt++;
      end
    end
    m_div = (m_div + 1) % (1 << (TB_BASE + TB_STEP * 3));
    m_valid = 1;
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // Per-cycle comparison against the model.
  always @(negedge clk) begin
    if (m_valid && !done) begin
      bit [7:0] exp_rd;
      exp_rd = {m_flag, m_ie, 2'(m_rate), 2'b00, m_wden, 1'b0};
      if (rd_data[7] != exp_rd[7]) check("R3 flag", rd_data, exp_rd);
      else if (rd_data[1] != exp_rd[1]) check("R7 wd enable", rd_data, exp_rd);
      else check("R2 register", rd_data, exp_rd);
      check("R6 irq", irq, m_flag && m_ie);
      check("R9 wd_rst", wd_rst, m_wdrst);
    end
  end

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic wait_no_tick();
    while (tick_next()) @(negedge clk);
  endtask

  initial begin
    int t0, t1, pulses, edges;
    repeat (4) @(negedge clk);
    check("R1 reset read", rd_data, 8'h30);
    check("R1 reset irq", irq, 0);
    check("R1 reset wd_rst", wd_rst, 0);
    rst = 1'b0;
    @(negedge clk);
    wait_no_tick();
    // Fields load, write-only bits read 0; this first write locks wd enable at 0.
    wr(8'h4D);
    check("R2 layout", rd_data & 8'h7F, 8'h40);
    wr(8'h42);
    check("R7 later write ignored", rd_data[1], 0);
    // Wait for a timeout, then check irq and bit-7 write has no effect.
    while (!rd_data[7]) @(negedge clk);
    check("R6 irq with flag and enable", irq, 1);
    wait_no_tick();
    wr(8'h40);
    check("R4 flag survives write w/o clear", rd_data[7], 1);
    wait_no_tick();
    wr(8'h48);
    check("R4 clear strobe", rd_data[7], 0);
    wait_no_tick();
    wr(8'hC0);
    check("R4 bit7 write ignored", rd_data[7], 0);
    // Collision of timeout and clear.
    while (!tick_next()) @(negedge clk);
    wr(8'h48);
    check("R5 set wins", rd_data[7], 1);
    wait_no_tick();
    wr(8'h00);
    check("R6 irq off with enable 0", irq, 0);
    // Rate change spacing.
    wr(8'h28);
    while (!rd_data[7]) @(negedge clk);
    t0 = cyc;
    wr(8'h28);
    while (!rd_data[7]) @(negedge clk);
    t1 = cyc;
    check("R11 spacing rate 2", t1 - t0, 16);
    // Mid-run reset: divider phase must survive.
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    edges = (31 - (m_div % 32)) + 1;
    t0 = cyc;
    while (!rd_data[7] && cyc - t0 < 64) @(negedge clk);
    check("R8 first timeout after reset", cyc - t0, edges);
    // Watchdog: first write enables it.
    wait_no_tick();
    wr(8'h03);
    check("R7 first write accepted", rd_data[1], 1);
    pulses = 0;
    for (int i = 0; i < 20; i++) begin
      repeat (6) begin @(negedge clk); pulses += wd_rst; end
      wr(8'h01);
      pulses += wd_rst;
    end
    check("R10 cleared watchdog silent", pulses, 0);
    pulses = 0;
    for (int i = 0; i < 64; i++) begin @(negedge clk); pulses += wd_rst; end
    check("R9 starved watchdog pulses", pulses, 4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule